// File: doc/BRIEF.md
# Dual-Port Mailbox RAM with Doorbells

This block is a 1024-byte memory that two independent hosts share. The hosts are called left and right. Each host has its own synchronous port, and both ports run on a single common clock. Either host can read or write any byte at any time. Shared structures, such as an identity byte that one host stores at location 0 for the other to read, live in ordinary locations.

The two highest addresses are doorbell slots. When left writes 0x3FF, the right interrupt goes low. When right reads 0x3FF, that interrupt is released. In the other direction, right writes 0x3FE to interrupt left, and left reads 0x3FE to release it. Each doorbell slot keeps the byte written to it, so the ring can carry an 8-bit message code.

Every access is taken in the cycle its strobes are high. No back-pressure exists: there is no ready signal, so a host never stalls. The only contention case is a write by both sides to the same address. In that case, right is told through its busy pin that its write was dropped.

Top module: `mailbox_ram`

## Requirements
- R1: After reset, `l_int_n` and `r_int_n` are both high (deasserted).
- R2: A read is a cycle with `cs` and `rd` high. It returns the addressed byte on that side's `rdata` on the following clock edge. A byte written by one side (`cs` and `we` high) can be read back unchanged by either side.
- R3: When one side reads an address in the same cycle the other side writes it, the reader gets the byte held before that write.
- R4: When both sides write the same address in the same cycle, the left byte is stored and `r_busy` is high in that cycle.
- R5: `r_busy` is low whenever the two sides are not both writing one address, including when they write different addresses.
- R6: A left write to 0x3FF drives `r_int_n` low from the next edge. The written byte stays readable at 0x3FF.
- R7: A right read of 0x3FF drives `r_int_n` high from the next edge. The read also returns the doorbell byte.
- R8: A right write to 0x3FE drives `l_int_n` low from the next edge. A left read of 0x3FE drives it high again.
- R9: If a doorbell is rung and cleared in the same cycle, the interrupt ends up asserted (set wins).
- R10: Only the peer's write sets a doorbell, and only the owner's read clears it. A left read of 0x3FF, or a right write to 0x3FF, changes neither interrupt.
- R11: In a cycle without a read strobe, that side's `rdata` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_cs | input | 1 | Left select |
| l_we | input | 1 | Left write enable |
| l_rd | input | 1 | Left read strobe |
| l_addr | input | 10 | Left byte address |
| l_wdata | input | 8 | Left write byte |
| l_rdata | output | 8 | Left read byte, registered |
| l_int_n | output | 1 | Interrupt to left, active low |
| r_cs | input | 1 | Right select |
| r_we | input | 1 | Right write enable |
| r_rd | input | 1 | Right read strobe |
| r_addr | input | 10 | Right byte address |
| r_wdata | input | 8 | Right write byte |
| r_rdata | output | 8 | Right read byte, registered |
| r_int_n | output | 1 | Interrupt to right, active low |
| r_busy | output | 1 | Right write lost to a left write this cycle |

## Verification
The hardest cases need both ports to hit one address in the same cycle. These are a dual write, a doorbell ring that meets the owner's clearing read, and a read racing a write. A single host driving one port can never produce them. The stimulus table therefore gives every row a full left and right request for one cycle, so each collision is one row. The row after each collision reads the cell back, which shows which byte was stored and what state the doorbell settled into.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_AW = 10;
  localparam int unsigned MBX_DW = 8;
  localparam int unsigned MBX_SIDES = 2;

  typedef enum logic {
    SIDE_L = 1'b0,
    SIDE_R = 1'b1
  } side_e;

  function automatic int unsigned peer_of(input int unsigned s);
    return (s == 0) ? 1 : 0;
  endfunction
endpackage

// File: rtl/mbx_collide.sv
module mbx_collide #(
  parameter int unsigned AW = mbx_pkg::MBX_AW
) (
  input  logic          l_wr,
  input  logic          r_wr,
  input  logic [AW-1:0] l_addr,
  input  logic [AW-1:0] r_addr,
  output logic          l_wr_ok,
  output logic          r_wr_ok,
  output logic          r_busy
);
  logic same_cell;

  always_comb begin
    same_cell = (l_addr == r_addr);
    l_wr_ok   = l_wr;
    r_busy    = l_wr && r_wr && same_cell;
    r_wr_ok   = r_wr && !r_busy;
  end
endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int unsigned AW = mbx_pkg::MBX_AW,
  parameter int unsigned DW = mbx_pkg::MBX_DW
) (
  input  logic          clk,
  input  logic          wr_en   [mbx_pkg::MBX_SIDES],
  input  logic [AW-1:0] wr_addr [mbx_pkg::MBX_SIDES],
  input  logic [DW-1:0] wr_data [mbx_pkg::MBX_SIDES],
  input  logic          rd_en   [mbx_pkg::MBX_SIDES],
  input  logic [AW-1:0] rd_addr [mbx_pkg::MBX_SIDES],
  output logic [DW-1:0] rd_data [mbx_pkg::MBX_SIDES]
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  // both write ports in one process; collision already resolved upstream
  always_ff @(posedge clk) begin
    for (int s = 0; s < int'(mbx_pkg::MBX_SIDES); s++) begin
      if (wr_en[s]) cells[wr_addr[s]] <= wr_data[s];
    end
  end

  // registered read: sees the content before this edge's writes
  for (genvar g = 0; g < int'(mbx_pkg::MBX_SIDES); g++) begin : g_rport
    always_ff @(posedge clk) begin
      if (rd_en[g]) rd_data[g] <= cells[rd_addr[g]];
    end
  end
endmodule

// File: rtl/mbx_bell.sv
module mbx_bell #(
  parameter int unsigned AW = mbx_pkg::MBX_AW,
  parameter logic [AW-1:0] SLOT = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          peer_wr,
  input  logic [AW-1:0] peer_addr,
  input  logic          own_rd,
  input  logic [AW-1:0] own_addr,
  output logic          int_n
);
  logic ring, ack, pending;

  always_comb begin
    ring = peer_wr && (peer_addr == SLOT);
    ack  = own_rd && (own_addr == SLOT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pending <= 1'b0;
    else if (ring) pending <= 1'b1;
    else if (ack)  pending <= 1'b0;
  end

  assign int_n = !pending;
endmodule

// File: rtl/mailbox_ram.sv
module mailbox_ram #(
  parameter int unsigned AW = mbx_pkg::MBX_AW,
  parameter int unsigned DW = mbx_pkg::MBX_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_cs,
  input  logic          l_we,
  input  logic          l_rd,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_int_n,
  input  logic          r_cs,
  input  logic          r_we,
  input  logic          r_rd,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_int_n,
  output logic          r_busy
);
  import mbx_pkg::*;

  localparam int unsigned NS = MBX_SIDES;
  localparam logic [AW-1:0] SLOT_TO_R = {AW{1'b1}};
  localparam logic [AW-1:0] SLOT_TO_L = SLOT_TO_R - 1'b1;

  logic          wr_req [NS];
  logic          wr_ok  [NS];
  logic          rd_req [NS];
  logic [AW-1:0] addr   [NS];
  logic [DW-1:0] wdata  [NS];
  logic [DW-1:0] rdata  [NS];
  logic          irq_n  [NS];

  always_comb begin
    wr_req[SIDE_L] = l_cs && l_we;
    wr_req[SIDE_R] = r_cs && r_we;
    rd_req[SIDE_L] = l_cs && l_rd;
    rd_req[SIDE_R] = r_cs && r_rd;
    addr[SIDE_L]   = l_addr;
    addr[SIDE_R]   = r_addr;
    wdata[SIDE_L]  = l_wdata;
    wdata[SIDE_R]  = r_wdata;
  end

  mbx_collide #(.AW(AW)) u_collide (
    .l_wr    (wr_req[SIDE_L]),
    .r_wr    (wr_req[SIDE_R]),
    .l_addr  (l_addr),
    .r_addr  (r_addr),
    .l_wr_ok (wr_ok[SIDE_L]),
    .r_wr_ok (wr_ok[SIDE_R]),
    .r_busy  (r_busy)
  );

  mbx_store #(.AW(AW), .DW(DW)) u_store (
    .clk     (clk),
    .wr_en   (wr_ok),
    .wr_addr (addr),
    .wr_data (wdata),
    .rd_en   (rd_req),
    .rd_addr (addr),
    .rd_data (rdata)
  );

  // one doorbell per side: rung by the peer's kept write, cleared by own read
  for (genvar s = 0; s < int'(NS); s++) begin : g_bell
    localparam int unsigned P = peer_of(s);
    localparam logic [AW-1:0] SLOT = (s == 0) ? SLOT_TO_L : SLOT_TO_R;
    mbx_bell #(.AW(AW), .SLOT(SLOT)) u_bell (
      .clk       (clk),
      .rst_n     (rst_n),
      .peer_wr   (wr_ok[P]),
      .peer_addr (addr[P]),
      .own_rd    (rd_req[s]),
      .own_addr  (addr[s]),
      .int_n     (irq_n[s])
    );
  end

  assign l_rdata = rdata[SIDE_L];
  assign r_rdata = rdata[SIDE_R];
  assign l_int_n = irq_n[SIDE_L];
  assign r_int_n = irq_n[SIDE_R];
endmodule

// File: rtl/mailbox_ram_chk.sv
module mailbox_ram_chk #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l_cs,
  input logic          l_we,
  input logic          l_rd,
  input logic [AW-1:0] l_addr,
  input logic [DW-1:0] l_rdata,
  input logic          l_int_n,
  input logic          r_cs,
  input logic          r_we,
  input logic          r_rd,
  input logic [AW-1:0] r_addr,
  input logic [DW-1:0] r_rdata,
  input logic          r_int_n,
  input logic          r_busy
);
  localparam logic [AW-1:0] TOP = {AW{1'b1}};
  localparam logic [AW-1:0] TOP_M1 = TOP - 1'b1;

  // R1
  int_idle_after_reset_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (l_int_n && r_int_n));

  // R6
  ring_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_cs && l_we && l_addr == TOP) |=> !r_int_n);

  // R8
  ring_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_cs && r_we && r_addr == TOP_M1 && !(l_cs && l_we && l_addr == TOP_M1)) |=> !l_int_n);

  // R7
  ack_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_cs && r_rd && r_addr == TOP && !(l_cs && l_we && l_addr == TOP)) |=> r_int_n);

  // R10
  right_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(r_int_n) |-> $past(l_cs && l_we && l_addr == TOP));

  // R4
  busy_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_busy |-> (r_cs && r_we && l_cs && l_we));

  // R11
  left_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_cs && l_rd) |=> $stable(l_rdata));

  // R11
  right_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(r_cs && r_rd) |=> $stable(r_rdata));
endmodule

bind mailbox_ram mailbox_ram_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_cs(l_cs), .l_we(l_we), .l_rd(l_rd), .l_addr(l_addr),
  .l_rdata(l_rdata), .l_int_n(l_int_n),
  .r_cs(r_cs), .r_we(r_we), .r_rd(r_rd), .r_addr(r_addr),
  .r_rdata(r_rdata), .r_int_n(r_int_n), .r_busy(r_busy)
);

// File: tb/sim_mailbox_ram.sv
module sim_mailbox_ram;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       l_cs = 0, l_we = 0, l_rd = 0;
  logic [9:0] l_addr = '0;
  logic [7:0] l_wdata = '0;
  logic [7:0] l_rdata;
  logic       l_int_n;
  logic       r_cs = 0, r_we = 0, r_rd = 0;
  logic [9:0] r_addr = '0;
  logic [7:0] r_wdata = '0;
  logic [7:0] r_rdata;
  logic       r_int_n;
  logic       r_busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  mailbox_ram u0 (.*);

  typedef struct packed {
    logic       lw, lr;
    logic [9:0] la;
    logic [7:0] ld;
    logic       rw, rr;
    logic [9:0] ra;
    logic [7:0] rd;
    logic       cl;
    logic [7:0] el;
    logic       cr;
    logic [7:0] er;
    logic       eli, eri, eb;
  } vec_t;

  localparam int NV = 20;
  // lw lr la ld | rw rr ra rd | cl el | cr er | l_int_n r_int_n busy
  localparam vec_t VEC [NV] = '{
    '{1,0,10'h000,8'hA5, 0,0,10'h000,8'h00, 0,8'h00, 0,8'h00, 1,1,0}, // R2 id byte
    '{0,0,10'h000,8'h00, 0,1,10'h000,8'h00, 0,8'h00, 1,8'hA5, 1,1,0}, // R2
    '{1,0,10'h011,8'hC3, 1,0,10'h010,8'h3C, 0,8'h00, 0,8'h00, 1,1,0}, // R5
    '{0,1,10'h010,8'h00, 0,1,10'h011,8'h00, 1,8'h3C, 1,8'hC3, 1,1,0}, // R2
    '{1,0,10'h020,8'h11, 1,0,10'h020,8'h22, 0,8'h00, 0,8'h00, 1,1,1}, // R4
    '{0,1,10'h020,8'h00, 0,1,10'h020,8'h00, 1,8'h11, 1,8'h11, 1,1,0}, // R4
    '{1,0,10'h030,8'h77, 0,0,10'h000,8'h00, 0,8'h00, 0,8'h00, 1,1,0},
    '{1,0,10'h030,8'h88, 0,1,10'h030,8'h00, 0,8'h00, 1,8'h77, 1,1,0}, // R3
    '{0,0,10'h000,8'h00, 0,1,10'h030,8'h00, 0,8'h00, 1,8'h88, 1,1,0}, // R3
    '{1,0,10'h3FF,8'h5A, 0,0,10'h000,8'h00, 0,8'h00, 0,8'h00, 1,0,0}, // R6
    '{0,0,10'h000,8'h00, 0,0,10'h000,8'h00, 1,8'h11, 1,8'h88, 1,0,0}, // R11
    '{0,1,10'h3FF,8'h00, 0,0,10'h000,8'h00, 1,8'h5A, 0,8'h00, 1,0,0}, // R10 R6
    '{0,0,10'h000,8'h00, 1,0,10'h3FF,8'h99, 0,8'h00, 0,8'h00, 1,0,0}, // R10
    '{0,0,10'h000,8'h00, 0,1,10'h3FF,8'h00, 0,8'h00, 1,8'h99, 1,1,0}, // R7
    '{0,0,10'h000,8'h00, 1,0,10'h3FE,8'hE1, 0,8'h00, 0,8'h00, 0,1,0}, // R8
    '{0,1,10'h3FE,8'h00, 0,0,10'h000,8'h00, 1,8'hE1, 0,8'h00, 1,1,0}, // R8
    '{0,1,10'h3FE,8'h00, 1,0,10'h3FE,8'hE2, 1,8'hE1, 0,8'h00, 0,1,0}, // R9
    '{0,1,10'h3FE,8'h00, 0,0,10'h000,8'h00, 1,8'hE2, 0,8'h00, 1,1,0}, // R8
    '{1,0,10'h3FF,8'hF0, 0,1,10'h3FF,8'h00, 0,8'h00, 1,8'h99, 1,0,0}, // R9
    '{0,0,10'h000,8'h00, 0,1,10'h3FF,8'h00, 0,8'h00, 1,8'hF0, 1,1,0}  // R7
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    l_cs = v.lw | v.lr; l_we = v.lw; l_rd = v.lr; l_addr = v.la; l_wdata = v.ld;
    r_cs = v.rw | v.rr; r_we = v.rw; r_rd = v.rr; r_addr = v.ra; r_wdata = v.rd;
  endtask

  task automatic idle();
    l_cs = 0; l_we = 0; l_rd = 0; r_cs = 0; r_we = 0; r_rd = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset l_int_n", {7'd0, l_int_n}, 8'd1);
    check("R1 reset r_int_n", {7'd0, r_int_n}, 8'd1);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      #1;
      check($sformatf("R4/R5 busy vec%0d", i), {7'd0, r_busy}, {7'd0, VEC[i].eb});
      @(posedge clk);
      #1;
      if (VEC[i].cl) check($sformatf("R2/R3 l_rdata vec%0d", i), l_rdata, VEC[i].el);
      if (VEC[i].cr) check($sformatf("R2/R3 r_rdata vec%0d", i), r_rdata, VEC[i].er);
      check($sformatf("R6-R10 l_int_n vec%0d", i), {7'd0, l_int_n}, {7'd0, VEC[i].eli});
      check($sformatf("R6-R10 r_int_n vec%0d", i), {7'd0, r_int_n}, {7'd0, VEC[i].eri});
    end

    // R4: dual write on a doorbell slot, left byte kept and right rung
    @(negedge clk);
    l_cs = 1; l_we = 1; l_addr = 10'h3FF; l_wdata = 8'h3D;
    r_cs = 1; r_we = 1; r_addr = 10'h3FF; r_wdata = 8'h4E;
    #1 check("R4 busy on doorbell slot", {7'd0, r_busy}, 8'd1);
    @(negedge clk);
    idle();
    check("R6 ring by kept left write", {7'd0, r_int_n}, 8'd0);
    check("R10 left not rung", {7'd0, l_int_n}, 8'd1);
    r_cs = 1; r_rd = 1; r_addr = 10'h3FF;
    @(negedge clk);
    idle();
    check("R4 left byte stored", r_rdata, 8'h3D);

    // R1: reset while both interrupts are pending
    l_cs = 1; l_we = 1; l_addr = 10'h3FF; l_wdata = 8'h01;
    r_cs = 1; r_we = 1; r_addr = 10'h3FE; r_wdata = 8'h02;
    @(negedge clk);
    idle();
    check("R6 pending before reset", {7'd0, r_int_n}, 8'd0);
    check("R8 pending before reset", {7'd0, l_int_n}, 8'd0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 l_int_n after reset", {7'd0, l_int_n}, 8'd1);
    check("R1 r_int_n after reset", {7'd0, r_int_n}, 8'd1);
    rst_n = 1'b1;
    @(negedge clk);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule